// File: doc/BRIEF.md
# Configurable Output Macrocell for a Sum-of-Products Logic Array

This block is one output cell of an eight-output programmable sum-of-products device. It receives the product terms that the AND array produces for its output and applies a set of configuration bits. From these it builds three things: the value to drive onto the pin, an active-high tri-state enable for the pad model, and the signal that goes back into the AND array as feedback. The cell holds one D flip-flop and an exclusive-OR stage that sets the output polarity. Four selectors then route the result: term use, enable source, output source and feedback source.

The configuration code is three bits, written here as `{cfg_g0, cfg_g1, cfg_l0}`. The two global bits are shared by all eight cells and `cfg_l0` belongs to this cell. A decoder turns the code into one of five operating modes, named MODE_REG, MODE_RIO, MODE_COMB, MODE_INPUT and MODE_NIO. Any code outside these five becomes MODE_BAD. The decoded mode is a pure function of the configuration inputs, so there are no state transitions between modes. The only state in the cell is the flip-flop.

A second local bit, `cfg_pol`, picks the output polarity. The parameter `CELL_KIND` selects the cell variant:
- 0: a plain cell.
- 1: an edge cell. Its adjacent input is the clock pin or the OE pin, and the global bit `cfg_g0` steers its feedback selector.
- 2: a cell that has no feedback as a dedicated combinatorial output and cannot serve as a dedicated input.

Top module: `macro_cell`

## Requirements
- R1: With code 010 (MODE_REG) the register loads the OR of all terms on the rising clock edge. `pad_en_o` follows `oe_pin_i` (1 enables). `pad_drive_o` is the stored bit XOR NOT `cfg_pol`. In plain cells `fb_o` is the stored bit.
- R2: With code 011 (MODE_RIO) only terms 1 to NUM_TERMS-1 are ORed, and term 0 drives `pad_en_o`. In plain cells `fb_o` is `own_pin_i`.
- R3: With code 100 (MODE_COMB) all terms are ORed and `pad_en_o` is always 1. In plain cells `fb_o` is `adj_pin_i`.
- R4: With code 101 (MODE_INPUT) `pad_en_o` and `pad_drive_o` are 0. In plain cells `fb_o` is `adj_pin_i`.
- R5: With code 111 (MODE_NIO) term 0 drives `pad_en_o`, terms 1 to NUM_TERMS-1 are ORed, and `fb_o` is `own_pin_i`.
- R6: Outside MODE_REG, MODE_INPUT and MODE_BAD, `pad_drive_o` equals the OR sum when `cfg_pol`=1 and its inverse when `cfg_pol`=0.
- R7: In an edge cell the feedback selector uses `{cfg_g0, cfg_l0}` in place of `{cfg_g1, cfg_l0}`: 10 gives the stored bit, 11 gives `own_pin_i`, and 00 or 01 gives `adj_pin_i`.
- R8: Codes 000, 001 and 110 force `pad_en_o`, `pad_drive_o` and `fb_o` to 0 and set `cfg_err_o` to 1. Every listed mode holds `cfg_err_o` at 0.
- R9: In a no-feedback cell `fb_o` is 0 in MODE_COMB, and code 101 behaves as an undefined code under R8.
- R10: An active-low `rst_n` clears the stored bit to 0. In MODE_REG with `cfg_pol`=0 this gives `pad_drive_o`=1 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the stored bit |
| pterm_i | input | NUM_TERMS | Product terms from the AND array; bit 0 can act as the enable term |
| oe_pin_i | input | 1 | Shared output-enable pin, 1 enables, used in MODE_REG |
| adj_pin_i | input | 1 | Pin value of the neighbouring cell (clock or OE pin for edge cells) |
| own_pin_i | input | 1 | Value read back from this cell's own pin |
| cfg_g0 | input | 1 | Global bit 0 (0 = device uses registers) |
| cfg_g1 | input | 1 | Global bit 1 |
| cfg_l0 | input | 1 | Local mode bit |
| cfg_pol | input | 1 | Local polarity bit, 1 = active high |
| pad_drive_o | output | 1 | Value to drive onto the pin |
| pad_en_o | output | 1 | Tri-state enable toward the pad, 1 drives |
| fb_o | output | 1 | Feedback into the AND array |
| cfg_err_o | output | 1 | Configuration code not in the mode table |

## Verification
The bench builds three copies of the cell, one for each `CELL_KIND` value (0, 1 and 2), with the default eight terms. It feeds the same stimulus to all three, so the edge-cell feedback rule and the no-feedback rule can be compared directly against the plain cell. On every cycle it sweeps all eight configuration codes, both polarities, all 256 term patterns and all combinations of the OE, adjacent-pin and own-pin inputs. It keeps a model of each stored bit, which covers the registered paths and the edge cell's feedback from the register in the non-registered codes.

// File: rtl/macro_cell_pkg.sv
package macro_cell_pkg;

    typedef enum logic [2:0] {
        MODE_REG   = 3'd0,
        MODE_RIO   = 3'd1,
        MODE_COMB  = 3'd2,
        MODE_INPUT = 3'd3,
        MODE_NIO   = 3'd4,
        MODE_BAD   = 3'd5
    } cell_mode_e;

    localparam int KIND_PLAIN = 0;
    localparam int KIND_EDGE  = 1;
    localparam int KIND_NOFB  = 2;

endpackage

// File: rtl/macro_mode_dec.sv
module macro_mode_dec
    import macro_cell_pkg::*;
#(
    parameter int CELL_KIND = KIND_PLAIN
) (
    input  logic       cfg_g0,
    input  logic       cfg_g1,
    input  logic       cfg_l0,
    output cell_mode_e mode_o,
    output logic       err_o
);
    localparam bit NO_INPUT = (CELL_KIND == KIND_NOFB);

    cell_mode_e raw_mode;

    always_comb begin
        unique case ({cfg_g0, cfg_g1, cfg_l0})
            3'b010:  raw_mode = MODE_REG;
            3'b011:  raw_mode = MODE_RIO;
            3'b100:  raw_mode = MODE_COMB;
            3'b101:  raw_mode = MODE_INPUT;
            3'b111:  raw_mode = MODE_NIO;
            default: raw_mode = MODE_BAD;
        endcase
    end

    always_comb begin
        if (NO_INPUT && raw_mode == MODE_INPUT) begin
            mode_o = MODE_BAD;
        end else begin
            mode_o = raw_mode;
        end
        err_o = (mode_o == MODE_BAD);
    end

endmodule

// File: rtl/macro_term_sel.sv
module macro_term_sel
    import macro_cell_pkg::*;
#(
    parameter int NUM_TERMS = 8
) (
    input  logic [NUM_TERMS-1:0] pterm_i,
    input  cell_mode_e           mode_i,
    output logic                 sum_o,
    output logic                 term_en_o
);
    localparam int TOP = NUM_TERMS - 1;

    logic full_or;
    logic part_or;

    always_comb begin
        full_or = |pterm_i;
        part_or = |pterm_i[TOP:1];
    end

    always_comb begin
        unique case (mode_i)
            MODE_REG, MODE_COMB: sum_o = full_or;
            MODE_RIO, MODE_NIO:  sum_o = part_or;
            default:             sum_o = 1'b0;
        endcase
        term_en_o = pterm_i[0];
    end

endmodule

// File: rtl/macro_fb_sel.sv
module macro_fb_sel
    import macro_cell_pkg::*;
#(
    parameter int CELL_KIND = KIND_PLAIN
) (
    input  logic       cfg_g0,
    input  logic       cfg_g1,
    input  logic       cfg_l0,
    input  cell_mode_e mode_i,
    input  logic       q_i,
    input  logic       own_pin_i,
    input  logic       adj_pin_i,
    output logic       fb_o
);
    localparam bit USE_G0 = (CELL_KIND == KIND_EDGE);

    logic sel_hi;
    logic mux_out;
    logic suppress;

    generate
        if (CELL_KIND == KIND_NOFB) begin : g_nofb
            assign suppress = (mode_i == MODE_COMB) || (mode_i == MODE_BAD);
        end else begin : g_fb
            assign suppress = (mode_i == MODE_BAD);
        end
    endgenerate

    always_comb begin
        sel_hi = USE_G0 ? cfg_g0 : cfg_g1;
        unique case ({sel_hi, cfg_l0})
            2'b10:   mux_out = q_i;
            2'b11:   mux_out = own_pin_i;
            default: mux_out = adj_pin_i;
        endcase
        fb_o = suppress ? 1'b0 : mux_out;
    end

endmodule

// File: rtl/macro_cell.sv
module macro_cell
    import macro_cell_pkg::*;
#(
    parameter int NUM_TERMS = 8,
    parameter int CELL_KIND = KIND_PLAIN
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_TERMS-1:0] pterm_i,
    input  logic                 oe_pin_i,
    input  logic                 adj_pin_i,
    input  logic                 own_pin_i,
    input  logic                 cfg_g0,
    input  logic                 cfg_g1,
    input  logic                 cfg_l0,
    input  logic                 cfg_pol,
    output logic                 pad_drive_o,
    output logic                 pad_en_o,
    output logic                 fb_o,
    output logic                 cfg_err_o
);
    cell_mode_e mode;
    logic       mode_err;
    logic       sum;
    logic       term_en;
    logic       q_state;
    logic       q_next;

    macro_mode_dec #(.CELL_KIND(CELL_KIND)) u_dec (
        .cfg_g0 (cfg_g0),
        .cfg_g1 (cfg_g1),
        .cfg_l0 (cfg_l0),
        .mode_o (mode),
        .err_o  (mode_err)
    );

    macro_term_sel #(.NUM_TERMS(NUM_TERMS)) u_terms (
        .pterm_i   (pterm_i),
        .mode_i    (mode),
        .sum_o     (sum),
        .term_en_o (term_en)
    );

    macro_fb_sel #(.CELL_KIND(CELL_KIND)) u_fb (
        .cfg_g0    (cfg_g0),
        .cfg_g1    (cfg_g1),
        .cfg_l0    (cfg_l0),
        .mode_i    (mode),
        .q_i       (q_state),
        .own_pin_i (own_pin_i),
        .adj_pin_i (adj_pin_i),
        .fb_o      (fb_o)
    );

    // State register process
    always_comb q_next = sum;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_state <= 1'b0;
        end else begin
            q_state <= q_next;
        end
    end

    // Output process
    always_comb begin
        unique case (mode)
            MODE_REG: begin
                pad_en_o    = oe_pin_i;
                pad_drive_o = q_state ^ ~cfg_pol;
            end
            MODE_RIO, MODE_NIO: begin
                pad_en_o    = term_en;
                pad_drive_o = sum ^ ~cfg_pol;
            end
            MODE_COMB: begin
                pad_en_o    = 1'b1;
                pad_drive_o = sum ^ ~cfg_pol;
            end
            default: begin
                pad_en_o    = 1'b0;
                pad_drive_o = 1'b0;
            end
        endcase
        cfg_err_o = mode_err;
    end

    // Requirement guards
    a_r8_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |-> (!pad_en_o && !pad_drive_o && !fb_o));

    a_r3_comb_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_COMB) |-> pad_en_o);

    a_r4_input_off: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_INPUT) |-> (!pad_en_o && !pad_drive_o));

    a_r5_term_enable: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MODE_RIO) || (mode == MODE_NIO)) |-> (pad_en_o == pterm_i[0]));

    a_r1_reg_capture: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode == MODE_REG) && (mode == MODE_REG) && $stable(cfg_pol))
        |-> (pad_drive_o == ($past(|pterm_i) ^ ~cfg_pol)));

    a_r9_no_feedback: assert property (@(posedge clk) disable iff (!rst_n)
        ((CELL_KIND == KIND_NOFB) && (mode == MODE_COMB)) |-> !fb_o);

endmodule

// File: tb/macro_cell_bench.sv
`timescale 1ns/1ps
module macro_cell_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] terms = 8'h00;
    logic       oe = 1'b0, adj = 1'b0, own = 1'b0;
    logic       g0 = 1'b0, g1 = 1'b1, l0 = 1'b0, pol = 1'b0;

    logic [2:0] drv, en, fb, err;
    logic [2:0] q_exp;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    macro_cell #(.NUM_TERMS(8), .CELL_KIND(0)) u_macro_cell (
        .clk(clk), .rst_n(rst_n), .pterm_i(terms), .oe_pin_i(oe),
        .adj_pin_i(adj), .own_pin_i(own), .cfg_g0(g0), .cfg_g1(g1),
        .cfg_l0(l0), .cfg_pol(pol), .pad_drive_o(drv[0]), .pad_en_o(en[0]),
        .fb_o(fb[0]), .cfg_err_o(err[0]));

    macro_cell #(.NUM_TERMS(8), .CELL_KIND(1)) u_macro_cell_edge (
        .clk(clk), .rst_n(rst_n), .pterm_i(terms), .oe_pin_i(oe),
        .adj_pin_i(adj), .own_pin_i(own), .cfg_g0(g0), .cfg_g1(g1),
        .cfg_l0(l0), .cfg_pol(pol), .pad_drive_o(drv[1]), .pad_en_o(en[1]),
        .fb_o(fb[1]), .cfg_err_o(err[1]));

    macro_cell #(.NUM_TERMS(8), .CELL_KIND(2)) u_macro_cell_nofb (
        .clk(clk), .rst_n(rst_n), .pterm_i(terms), .oe_pin_i(oe),
        .adj_pin_i(adj), .own_pin_i(own), .cfg_g0(g0), .cfg_g1(g1),
        .cfg_l0(l0), .cfg_pol(pol), .pad_drive_o(drv[2]), .pad_en_o(en[2]),
        .fb_o(fb[2]), .cfg_err_o(err[2]));

    // mode numbers: 0 bad, 1 reg, 2 rio, 3 comb, 4 input, 5 nio
    function automatic int mode_of(int kind, logic a, logic b, logic c);
        case ({a, b, c})
            3'b010: return 1;
            3'b011: return 2;
            3'b100: return 3;
            3'b101: return (kind == 2) ? 0 : 4;
            3'b111: return 5;
            default: return 0;
        endcase
    endfunction

    function automatic logic sum_of(int m, logic [7:0] t);
        if (m == 1 || m == 3) return |t;
        if (m == 2 || m == 5) return |t[7:1];
        return 1'b0;
    endfunction

    task automatic check(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%b expected=%b cfg=%b%b%b pol=%b t=%h",
                     req, what, act, exp, g0, g1, l0, pol, terms);
        end
    endtask

    task automatic check_all();
        for (int k = 0; k < 3; k++) begin
            int    m;
            logic  s, e_en, e_drv, e_fb, selhi;
            string tag;
            m = mode_of(k, g0, g1, l0);
            s = sum_of(m, terms);
            case (m)
                1: begin e_en = oe;       e_drv = q_exp[k] ^ ~pol; tag = "R1"; end
                2: begin e_en = terms[0]; e_drv = s ^ ~pol;        tag = "R2"; end
                3: begin e_en = 1'b1;     e_drv = s ^ ~pol;        tag = "R3"; end
                4: begin e_en = 1'b0;     e_drv = 1'b0;            tag = "R4"; end
                5: begin e_en = terms[0]; e_drv = s ^ ~pol;        tag = "R5"; end
                default: begin e_en = 1'b0; e_drv = 1'b0;          tag = "R8"; end
            endcase
            selhi = (k == 1) ? g0 : g1;
            if (selhi && !l0)     e_fb = q_exp[k];
            else if (selhi && l0) e_fb = own;
            else                  e_fb = adj;
            if (m == 0) e_fb = 1'b0;
            if (k == 2 && m == 3) e_fb = 1'b0;
            check(tag, "pad_en", en[k], e_en);
            check((m == 2 || m == 3 || m == 5) ? "R6" : tag, "pad_drive", drv[k], e_drv);
            check((k == 1) ? "R7" : ((k == 2 && (m == 3 || ({g0, g1, l0} == 3'b101))) ? "R9" : tag),
                  "feedback", fb[k], e_fb);
            check("R8", "cfg_err", err[k], (m == 0));
        end
    endtask

    initial begin
        g0 = 1'b0; g1 = 1'b1; l0 = 1'b0; pol = 1'b0; terms = 8'hFF;
        q_exp = 3'b000;
        repeat (3) @(posedge clk);
        #1;
        // R10: stored bit cleared by reset, active-low output shows 1
        for (int k = 0; k < 3; k++) begin
            check("R10", "reset drive", drv[k], 1'b1);
            check("R10", "reset fb", fb[k], (k == 1) ? adj : 1'b0);
        end
        @(negedge clk);
        rst_n = 1'b1;
        for (int cfg = 0; cfg < 8; cfg++) begin
            for (int p = 0; p < 2; p++) begin
                for (int t = 0; t < 256; t++) begin
                    for (int sd = 0; sd < 8; sd++) begin
                        @(negedge clk);
                        {g0, g1, l0} = cfg[2:0];
                        pol = p[0];
                        terms = t[7:0];
                        {oe, adj, own} = sd[2:0];
                        #1;
                        check_all();
                        @(posedge clk);
                        for (int k = 0; k < 3; k++)
                            q_exp[k] = sum_of(mode_of(k, g0, g1, l0), terms);
                    end
                end
            end
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule